// File: doc/BRIEF.md
# Echoed-Clock Serial ADC Readout Controller

This block runs one conversion-and-readout cycle on a serial analog-to-digital converter that sends back a copy of the clock it receives. Working from the system clock, it raises a conversion-start strobe and waits out the converter's busy time. It then holds a serial-clock enable high for exactly one system cycle per data bit. The pad logic outside the block gates the transmitted clock with that enable.

The converter returns an echo clock. Its delay behind the transmitted clock can be longer than one system period, so its phase is unknown. A capture stage clocked only by that echo clock shifts the data in, most significant bit first. When a word is complete, the capture stage holds it and flips a ready toggle. In the system domain, a synchronizer chain carries the toggle across. When the block sees the toggle change, it latches the held word and raises a one-cycle valid pulse. The controller ignores requests until that delivery is done.

Top module: `echo_adc_reader`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `conv_strobe`, `sclk_en` and `sample_valid` are low and `sample_data` is zero.
- R2: A `sample_req` that is high at a rising clock edge while the controller is idle starts a conversion. `conv_strobe` goes high in the next cycle and stays high for exactly STROBE_CYC consecutive cycles (default 4).
- R3: `sclk_en` is never high while `conv_strobe` is high. The first `sclk_en` cycle comes exactly CONV_CYC cycles (default 25, i.e. 100 ns at 250 MHz) after the first strobe cycle.
- R4: Each conversion produces exactly WORD_W consecutive `sclk_en` cycles (default 16), with no other `sclk_en` activity.
- R5: `ser_data` is sampled on each rising edge of `echo_clk`. The first bit of a burst becomes bit WORD_W-1 (MSB) of `sample_data`, and the last bit becomes bit 0.
- R6: A finished word appears on `sample_data` together with a `sample_valid` pulse exactly one cycle wide. `sample_data` changes at no other time.
- R7: A `sample_req` sampled from the cycle in which the strobe is accepted through the cycle before `sample_valid` is raised is ignored. It is neither started nor stored for later.
- R8: The controller is idle in the cycle in which `sample_valid` is high. A `sample_req` sampled at the next rising edge starts a new strobe one cycle later.
- R9: Capture is correct for any fixed echo delay between 0 and 7 ns after the transmitted clock edge, including delays longer than one system period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (250 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| sample_req | input | 1 | Request for one conversion |
| echo_clk | input | 1 | Clock returned by the converter |
| ser_data | input | 1 | Serial data, valid at the rising edge of `echo_clk` |
| conv_strobe | output | 1 | Conversion-start strobe |
| sclk_en | output | 1 | Enable for the gated serial clock, one cycle per bit |
| sample_data | output | WORD_W | Last delivered sample |
| sample_valid | output | 1 | One-cycle pulse marking a new `sample_data` |

## Verification
The hardest case to reach is the boundary at the end of a conversion. There, a request lands in the last busy cycle or in the very cycle the word is delivered. The echo edges also fall at a phase unrelated to the system edge. The bench re-raises `sample_req` in the cycle it sees `sample_valid`, so back-to-back conversions land exactly on that boundary. Random requests fill the busy window. The converter model picks a fresh echo delay of 0 to 7 ns for each burst, so the toggle crosses at many different phases.

// File: rtl/echo_adc_pkg.sv
`timescale 1ns/1ps
package echo_adc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_STROBE  = 3'd1,
    ST_WAIT    = 3'd2,
    ST_BURST   = 3'd3,
    ST_COLLECT = 3'd4
  } rd_state_t;

  // width of a counter that must reach the value n
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // system cycle, counted from the first strobe cycle, in which the burst opens
  function automatic int unsigned burst_open_tick(input int unsigned conv_cyc);
    return conv_cyc;
  endfunction

endpackage

// File: rtl/echo_adc_seq.sv
`timescale 1ns/1ps
module echo_adc_seq
  import echo_adc_pkg::*;
#(
  parameter int unsigned WORD_W     = 16,
  parameter int unsigned STROBE_CYC = 4,
  parameter int unsigned CONV_CYC   = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_req,
  input  logic word_new,
  output logic conv_strobe,
  output logic sclk_en,
  output logic busy
);

  localparam int unsigned TW = cnt_width(CONV_CYC);
  localparam int unsigned BW = cnt_width(WORD_W);
  localparam logic [TW-1:0] STROBE_LAST = TW'(STROBE_CYC - 1);
  localparam logic [TW-1:0] WAIT_LAST   = TW'(burst_open_tick(CONV_CYC) - 1);
  localparam logic [BW-1:0] BIT_LAST    = BW'(WORD_W - 1);

  rd_state_t      state_q;
  logic [TW-1:0]  tick_q;
  logic [BW-1:0]  bit_q;

  // named events for the assertions
  logic start_accept;
  logic strobe_done;
  logic wait_done;
  logic burst_last;

  assign start_accept = (state_q == ST_IDLE) && sample_req;
  assign strobe_done  = (state_q == ST_STROBE) && (tick_q == STROBE_LAST);
  assign wait_done    = (state_q == ST_WAIT) && (tick_q == WAIT_LAST);
  assign burst_last   = (state_q == ST_BURST) && (bit_q == BIT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tick_q  <= '0;
      bit_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_accept) begin
            state_q <= ST_STROBE;
            tick_q  <= '0;
          end
        end
        ST_STROBE: begin
          tick_q <= tick_q + 1'b1;
          if (strobe_done) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          tick_q <= tick_q + 1'b1;
          if (wait_done) begin
            state_q <= ST_BURST;
            bit_q   <= '0;
          end
        end
        ST_BURST: begin
          bit_q <= bit_q + 1'b1;
          if (burst_last) state_q <= ST_COLLECT;
        end
        ST_COLLECT: begin
          if (word_new) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign conv_strobe = (state_q == ST_STROBE);
  assign sclk_en     = (state_q == ST_BURST);
  assign busy        = (state_q != ST_IDLE);

  // R3: strobe and serial clock never overlap
  p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_strobe |-> !sclk_en);

  // R2: strobe falls only after its full length
  p_strobe_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_strobe) |-> (tick_q == TW'(STROBE_CYC)));

  // R3: burst opens at the conversion-time boundary
  p_burst_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_en) |-> (tick_q == TW'(CONV_CYC)));

  // R4: burst closes right after its last bit
  p_burst_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    burst_last |=> !sclk_en);

  // R7: a request while busy leaves the strobe untouched
  p_req_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !conv_strobe) |=> !$rose(conv_strobe));

endmodule

// File: rtl/echo_adc_capture.sv
`timescale 1ns/1ps
module echo_adc_capture
  import echo_adc_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic              echo_clk,
  input  logic              rst_n,
  input  logic              ser_data,
  output logic [WORD_W-1:0] held_word,
  output logic              ready_tog
);

  localparam int unsigned BW = cnt_width(WORD_W);
  localparam logic [BW-1:0] BIT_LAST = BW'(WORD_W - 1);

  logic [WORD_W-1:0] shift_q;
  logic [BW-1:0]     bit_q;
  logic              word_last;
  logic [WORD_W-1:0] shift_next;

  assign word_last  = (bit_q == BIT_LAST);
  assign shift_next = {shift_q[WORD_W-2:0], ser_data};

  always_ff @(posedge echo_clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q   <= '0;
      bit_q     <= '0;
      held_word <= '0;
      ready_tog <= 1'b0;
    end else begin
      shift_q <= shift_next;
      if (word_last) begin
        bit_q     <= '0;
        held_word <= shift_next;
        ready_tog <= ~ready_tog;
      end else begin
        bit_q <= bit_q + 1'b1;
      end
    end
  end

  // R5: bit counter stays inside the word
  p_bit_range_r5: assert property (@(posedge echo_clk) disable iff (!rst_n)
    bit_q <= BIT_LAST);

  // R6: held word is frozen between word boundaries
  p_held_stable_r6: assert property (@(posedge echo_clk) disable iff (!rst_n)
    !word_last |=> $stable(held_word));

endmodule

// File: rtl/echo_adc_sync.sv
`timescale 1ns/1ps
module echo_adc_sync #(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ready_tog,
  input  logic [WORD_W-1:0] held_word,
  output logic              word_new,
  output logic [WORD_W-1:0] sample_data,
  output logic              sample_valid
);

  logic [SYNC_STAGES-1:0] chain_q;
  logic                   seen_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= ready_tog;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[SYNC_STAGES-2:0], ready_tog};
      end
    end
  endgenerate

  assign word_new = chain_q[SYNC_STAGES-1] ^ seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q       <= 1'b0;
      sample_data  <= '0;
      sample_valid <= 1'b0;
    end else begin
      seen_q       <= chain_q[SYNC_STAGES-1];
      sample_valid <= word_new;
      if (word_new) sample_data <= held_word;
    end
  end

  // R6: valid is a single-cycle pulse
  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid);

  // R6: data moves only together with valid
  p_data_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !word_new |=> $stable(sample_data));

endmodule

// File: rtl/echo_adc_reader.sv
`timescale 1ns/1ps
module echo_adc_reader #(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned STROBE_CYC  = 4,
  parameter int unsigned CONV_CYC    = 25,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_req,
  input  logic              echo_clk,
  input  logic              ser_data,
  output logic              conv_strobe,
  output logic              sclk_en,
  output logic [WORD_W-1:0] sample_data,
  output logic              sample_valid
);

  logic              word_new;
  logic              busy;
  logic [WORD_W-1:0] held_word;
  logic              ready_tog;

  echo_adc_seq #(
    .WORD_W     (WORD_W),
    .STROBE_CYC (STROBE_CYC),
    .CONV_CYC   (CONV_CYC)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_req  (sample_req),
    .word_new    (word_new),
    .conv_strobe (conv_strobe),
    .sclk_en     (sclk_en),
    .busy        (busy)
  );

  echo_adc_capture #(
    .WORD_W (WORD_W)
  ) u_cap (
    .echo_clk  (echo_clk),
    .rst_n     (rst_n),
    .ser_data  (ser_data),
    .held_word (held_word),
    .ready_tog (ready_tog)
  );

  echo_adc_sync #(
    .WORD_W      (WORD_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_sync (
    .clk          (clk),
    .rst_n        (rst_n),
    .ready_tog    (ready_tog),
    .held_word    (held_word),
    .word_new     (word_new),
    .sample_data  (sample_data),
    .sample_valid (sample_valid)
  );

  // R8: delivery returns the controller to idle
  p_idle_on_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> !busy);

  // R1: outputs quiet straight after reset release
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!sample_valid || rst_n));

endmodule

// File: tb/echo_adc_reader_bench.sv
`timescale 1ns/1ps
module echo_adc_reader_bench;

  localparam int W      = 16;
  localparam int STROBE = 4;
  localparam int CONV   = 25;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sample_req = 1'b0;
  logic         echo_clk = 1'b0;
  logic         ser_data = 1'b0;
  logic         conv_strobe;
  logic         sclk_en;
  logic [W-1:0] sample_data;
  logic         sample_valid;

  int tests = 0;
  int fails = 0;
  bit live  = 1'b0;

  always #2 clk = ~clk;

  echo_adc_reader #(
    .WORD_W(W), .STROBE_CYC(STROBE), .CONV_CYC(CONV), .SYNC_STAGES(2)
  ) u_echo_adc_reader (
    .clk(clk), .rst_n(rst_n), .sample_req(sample_req),
    .echo_clk(echo_clk), .ser_data(ser_data),
    .conv_strobe(conv_strobe), .sclk_en(sclk_en),
    .sample_data(sample_data), .sample_valid(sample_valid)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // gap from first strobe cycle to first burst cycle
  function automatic int exp_gap();
    return CONV;
  endfunction

  // MSB-first assembly of the bits the converter model sent
  function automatic logic [W-1:0] assemble(input logic [W-1:0] word);
    logic [W-1:0] r = '0;
    for (int i = 0; i < W; i++) r = {r[W-2:0], word[W-1-i]};
    return r;
  endfunction

  // converter model: echo clock with a random 0..7 ns lag per burst
  logic [W-1:0] exp_word = '0;
  initial begin
    forever begin
      @(negedge clk);
      if (live && sclk_en) begin
        logic [W-1:0] word;
        int d;
        word = W'($urandom);
        d = $urandom % 8;
        exp_word = assemble(word);
        #(d);
        for (int i = 0; i < W; i++) begin
          ser_data = word[W-1-i];
          #1 echo_clk = 1'b1;
          #2 echo_clk = 1'b0;
          #1;
        end
      end
    end
  end

  // monitor, sampling at the falling edge
  int           cyc = 0;
  int           rise_cyc = 0;
  int           strobe_len = 0;
  int           burst_len = 0;
  int           words = 0;
  bit           busy = 1'b0;
  logic         p_strobe = 1'b0, p_sclk = 1'b0, p_valid = 1'b0, p_req = 1'b0;
  logic [W-1:0] last_data = '0;

  always @(negedge clk) begin
    if (live) begin
      bit srise;
      cyc++;
      srise = conv_strobe && !p_strobe;
      if (p_req && !busy) chk(srise, "R8 accepted request starts strobe", srise, 1);
      else if (srise)     chk(1'b0, "R7 strobe without idle request", 1, 0);
      if (srise) begin
        busy = 1'b1;
        rise_cyc = cyc;
        strobe_len = 0;
      end
      if (conv_strobe) strobe_len++;
      if (!conv_strobe && p_strobe) chk(strobe_len == STROBE, "R2 strobe width", strobe_len, STROBE);
      if (conv_strobe && sclk_en) chk(1'b0, "R3 strobe overlaps sclk_en", 1, 0);
      if (sclk_en && !p_sclk) begin
        chk(cyc - rise_cyc == exp_gap(), "R3 conversion wait", cyc - rise_cyc, exp_gap());
        burst_len = 0;
      end
      if (sclk_en) burst_len++;
      if (!sclk_en && p_sclk) chk(burst_len == W, "R4 burst length", burst_len, W);
      if (sample_valid) begin
        chk(sample_data == exp_word, "R5 R9 captured word", sample_data, exp_word);
        chk(!p_valid, "R6 valid width", p_valid, 0);
        busy = 1'b0;
        words++;
      end else if (sample_data != last_data) begin
        chk(1'b0, "R6 data changed without valid", sample_data, last_data);
      end
      last_data = sample_data;
      p_strobe = conv_strobe;
      p_sclk   = sclk_en;
      p_valid  = sample_valid;
      p_req    = sample_req;
    end
  end

  // watchdog
  initial begin
    #(4 * 100000);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: quiet during reset
    chk(!conv_strobe && !sclk_en && !sample_valid && sample_data == '0,
        "R1 outputs in reset", {conv_strobe, sclk_en, sample_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!conv_strobe && !sclk_en && !sample_valid && sample_data == '0,
        "R1 outputs after reset", {conv_strobe, sclk_en, sample_valid}, 0);
    live = 1'b1;
    // directed: single request, then back-to-back requests on the delivery cycle
    for (int i = 0; i < 6000; i++) begin
      @(posedge clk);
      #1;
      if (i < 3000 && sample_valid) sample_req = 1'b1;
      else if (i < 3000)            sample_req = ($urandom % 6 == 0);
      else                          sample_req = ($urandom % 3 == 0);
    end
    sample_req = 1'b0;
    repeat (120) @(posedge clk);
    #1;
    chk(words > 40, "R5 words delivered", words, 41);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule